// File: doc/BRIEF.md
# Code Segment Register with Hidden Base Cache

This block holds the code-segment state of a segmented processor front end and produces the address of the next instruction fetch. The state has three parts. The visible 16-bit selector is what software sees. Behind it sits a hidden base and limit that software cannot read directly. The hidden pair is written only at the moment the selector is loaded. A real-mode load takes the base from the selector shifted left by four. A protected-mode load takes the base and limit from the descriptor values supplied on the inputs. Switching modes later leaves the cached pair alone. As a result, a base set up in protected mode keeps working after the core drops back to real mode.

The block also keeps the instruction offset. The offset can be reloaded on its own, which is how a near jump works, or in the same cycle as a selector load, which is how a far jump or an interrupt works. The fetch address is the hidden base plus the offset. It is computed without registers from the stored state and goes straight out as the physical fetch address, because paging is off. Reset loads a base that does not match the visible selector, so the first fetch lands just below the top of the 32-bit space. A comparison flag reports when the offset is past the cached limit. The flag only reports the condition and changes no state.

Top module: `codeseg_unit`

## Requirements
- R1: After reset, seg_sel is 0xF000, seg_base is 0xFFFF0000, seg_limit is 0x0000FFFF and ip_off is 0x0000FFF0.
- R2: fetch_addr equals seg_base plus the effective offset, and is used directly as the physical fetch address. With the reset state this gives 0xFFFFFFF0.
- R3: When sel_load is high and prot_mode is low, then on the next edge seg_sel takes sel_value, seg_base becomes sel_value shifted left by 4 bits (a 20-bit value, upper 12 bits zero), and seg_limit becomes 0x0000FFFF.
- R4: When sel_load is high and prot_mode is high, then on the next edge seg_sel takes sel_value, seg_base takes desc_base and seg_limit takes desc_limit. The selector value plays no part in the base.
- R5: A change of prot_mode alone leaves seg_sel, seg_base and seg_limit unchanged. A base loaded in protected mode stays in effect after a return to real mode.
- R6: When ip_load is high, ip_off takes ip_value on the next edge. Without a selector load in the same cycle, the base (including the reset base) does not change.
- R7: The effective offset is all 32 bits of ip_off when prot_mode is high. When prot_mode is low it is the low 16 bits of ip_off, zero-extended.
- R8: limit_fault is high exactly when the effective offset is greater than seg_limit, and raising it changes no stored state.
- R9: The base-plus-offset addition wraps modulo 2^32.
- R10: A selector load and an offset load in the same cycle both take effect on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads the reset state |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| sel_load | input | 1 | Single-cycle strobe that loads the selector |
| sel_value | input | 16 | Selector value to load |
| desc_base | input | 32 | Descriptor base, used on protected-mode loads |
| desc_limit | input | 32 | Descriptor limit, used on protected-mode loads |
| ip_load | input | 1 | Single-cycle strobe that loads the instruction offset |
| ip_value | input | 32 | Instruction offset to load |
| seg_sel | output | 16 | Visible selector |
| seg_base | output | 32 | Hidden base |
| seg_limit | output | 32 | Hidden limit |
| ip_off | output | 32 | Stored instruction offset |
| fetch_addr | output | 32 | Linear fetch address, also the physical fetch address |
| limit_fault | output | 1 | Effective offset is past the hidden limit |

## Verification
The bench builds the block with its default parameters: the 0xF000 / 0xFFFF0000 / 0xFFFF / 0xFFF0 reset set and the 0xFFFF real-mode limit. This places the very first fetch at the top of the 32-bit space. A plain near jump from that state is enough to show that the reset base survives any change that does not load a selector. A protected-mode base just below 2^32, together with a small offset, makes the address wrap around. A 17-bit offset used in both modes shows the real-mode truncation and makes the limit comparison fire.

// File: rtl/cseg_pkg.sv
package cseg_pkg;
  localparam int ADDR_W     = 32;
  localparam int SEL_W      = 16;
  localparam int SEG_SHIFT  = 4;
  localparam int REAL_OFF_W = 16;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [SEL_W-1:0]  sel_t;

  // Real-mode base: selector moved up by the segment shift
  function automatic addr_t real_base(input sel_t s);
    return addr_t'(s) << SEG_SHIFT;
  endfunction

  // Offset as the address path sees it in the current mode
  function automatic addr_t eff_offset(input addr_t off, input logic prot);
    return prot ? off : addr_t'(off[REAL_OFF_W-1:0]);
  endfunction

  // Linear address, wraps modulo 2^ADDR_W
  function automatic addr_t lin_addr(input addr_t base, input addr_t off);
    return base + off;
  endfunction
endpackage

// File: rtl/cseg_shadow.sv
module cseg_shadow
  import cseg_pkg::*;
#(
  parameter sel_t  RST_SEL    = 16'hF000,
  parameter addr_t RST_BASE   = 32'hFFFF_0000,
  parameter addr_t RST_LIMIT  = 32'h0000_FFFF,
  parameter addr_t REAL_LIMIT = 32'h0000_FFFF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  prot_mode,
  input  logic  sel_load,
  input  sel_t  sel_value,
  input  addr_t desc_base,
  input  addr_t desc_limit,
  output sel_t  sel_q,
  output addr_t base_q,
  output addr_t limit_q
);
  addr_t base_next, limit_next;

  always_comb begin
    if (prot_mode) begin
      base_next  = desc_base;
      limit_next = desc_limit;
    end else begin
      base_next  = real_base(sel_value);
      limit_next = REAL_LIMIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= RST_SEL;
      base_q  <= RST_BASE;
      limit_q <= RST_LIMIT;
    end else if (sel_load) begin
      sel_q   <= sel_value;
      base_q  <= base_next;
      limit_q <= limit_next;
    end
  end

  // R5: without a selector load the hidden pair never moves
  p_hidden_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_load |=> ($stable(base_q) && $stable(limit_q) && $stable(sel_q)));

  // R3: real-mode load derives base from selector
  p_real_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_load && !prot_mode) |=>
      (base_q[SEG_SHIFT-1:0] == '0) &&
      (base_q[SEG_SHIFT +: SEL_W] == $past(sel_value)) &&
      (limit_q == REAL_LIMIT));

  // R4: protected-mode load copies descriptor values
  p_prot_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_load && prot_mode) |=>
      (base_q == $past(desc_base)) && (limit_q == $past(desc_limit)) &&
      (sel_q == $past(sel_value)));
endmodule

// File: rtl/cseg_ip.sv
module cseg_ip
  import cseg_pkg::*;
#(
  parameter addr_t RST_OFF = 32'h0000_FFF0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ip_load,
  input  addr_t ip_value,
  output addr_t off_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       off_q <= RST_OFF;
    else if (ip_load) off_q <= ip_value;
  end

  // R6: offset only changes through its own strobe
  p_off_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ip_load |=> $stable(off_q));

  p_off_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ip_load |=> (off_q == $past(ip_value)));
endmodule

// File: rtl/cseg_fetch.sv
module cseg_fetch
  import cseg_pkg::*;
(
  input  logic  prot_mode,
  input  addr_t base,
  input  addr_t limit,
  input  addr_t off,
  output addr_t fetch_addr,
  output logic  over_limit
);
  addr_t eff;

  always_comb begin
    eff        = eff_offset(off, prot_mode);
    fetch_addr = lin_addr(base, eff);
    over_limit = (eff > limit);
  end
endmodule

// File: rtl/codeseg_unit.sv
module codeseg_unit
  import cseg_pkg::*;
#(
  parameter sel_t  RST_SEL    = 16'hF000,
  parameter addr_t RST_BASE   = 32'hFFFF_0000,
  parameter addr_t RST_LIMIT  = 32'h0000_FFFF,
  parameter addr_t RST_OFF    = 32'h0000_FFF0,
  parameter addr_t REAL_LIMIT = 32'h0000_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prot_mode,
  input  logic        sel_load,
  input  logic [15:0] sel_value,
  input  logic [31:0] desc_base,
  input  logic [31:0] desc_limit,
  input  logic        ip_load,
  input  logic [31:0] ip_value,
  output logic [15:0] seg_sel,
  output logic [31:0] seg_base,
  output logic [31:0] seg_limit,
  output logic [31:0] ip_off,
  output logic [31:0] fetch_addr,
  output logic        limit_fault
);
  sel_t  sel_w;
  addr_t base_w, limit_w, off_w, addr_w;
  logic  over_w;

  cseg_shadow #(
    .RST_SEL(RST_SEL), .RST_BASE(RST_BASE),
    .RST_LIMIT(RST_LIMIT), .REAL_LIMIT(REAL_LIMIT)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode),
    .sel_load(sel_load), .sel_value(sel_value),
    .desc_base(desc_base), .desc_limit(desc_limit),
    .sel_q(sel_w), .base_q(base_w), .limit_q(limit_w)
  );

  cseg_ip #(.RST_OFF(RST_OFF)) u_ip (
    .clk(clk), .rst_n(rst_n), .ip_load(ip_load),
    .ip_value(ip_value), .off_q(off_w)
  );

  cseg_fetch u_fetch (
    .prot_mode(prot_mode), .base(base_w), .limit(limit_w),
    .off(off_w), .fetch_addr(addr_w), .over_limit(over_w)
  );

  assign seg_sel     = sel_w;
  assign seg_base    = base_w;
  assign seg_limit   = limit_w;
  assign ip_off      = off_w;
  assign fetch_addr  = addr_w;
  assign limit_fault = over_w;

  // R6: a near jump keeps whatever base is cached
  p_near_keeps_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_load && !sel_load) |=> $stable(base_w));

  // R8: a fault leaves the stored state alone when no strobe is present
  p_fault_no_effect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (over_w && !sel_load && !ip_load) |=> ($stable(base_w) && $stable(off_w)));

  // R10: both strobes together land on the same edge
  p_joint_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_load && ip_load) |=>
      (sel_w == $past(sel_value)) && (off_w == $past(ip_value)));
endmodule

// File: tb/test_codeseg_unit.sv
module test_codeseg_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot_mode = 1'b0;
  logic        sel_load = 1'b0;
  logic [15:0] sel_value = '0;
  logic [31:0] desc_base = '0;
  logic [31:0] desc_limit = '0;
  logic        ip_load = 1'b0;
  logic [31:0] ip_value = '0;
  logic [15:0] seg_sel;
  logic [31:0] seg_base, seg_limit, ip_off, fetch_addr;
  logic        limit_fault;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  codeseg_unit i_codeseg_unit (
    .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode),
    .sel_load(sel_load), .sel_value(sel_value),
    .desc_base(desc_base), .desc_limit(desc_limit),
    .ip_load(ip_load), .ip_value(ip_value),
    .seg_sel(seg_sel), .seg_base(seg_base), .seg_limit(seg_limit),
    .ip_off(ip_off), .fetch_addr(fetch_addr), .limit_fault(limit_fault)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", what, act, exp);
    end
  endtask

  // bench-side address model: mode-dependent offset width, 32-bit wrap
  function automatic logic [31:0] model_addr(input logic [31:0] b, input logic [31:0] o,
                                             input logic p);
    logic [31:0] e;
    e = p ? o : {16'h0000, o[15:0]};
    return b + e;
  endfunction

  task automatic do_sel(input logic [15:0] s, input logic [31:0] db, input logic [31:0] dl);
    @(negedge clk);
    sel_load = 1'b1; sel_value = s; desc_base = db; desc_limit = dl;
    @(negedge clk);
    sel_load = 1'b0;
  endtask

  task automatic do_ip(input logic [31:0] v);
    @(negedge clk);
    ip_load = 1'b1; ip_value = v;
    @(negedge clk);
    ip_load = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 selector", {16'h0, seg_sel}, 32'h0000F000);
    chk("R1 base", seg_base, 32'hFFFF0000);
    chk("R1 limit", seg_limit, 32'h0000FFFF);
    chk("R1 offset", ip_off, 32'h0000FFF0);
    chk("R2 first fetch", fetch_addr, 32'hFFFFFFF0);
    chk("R8 no fault at reset", {31'h0, limit_fault}, 32'h0);
  endtask

  task automatic t_near_jump;
    do_ip(32'h0000_0100);
    chk("R6 base kept on near jump", seg_base, 32'hFFFF0000);
    chk("R6 offset loaded", ip_off, 32'h00000100);
    chk("R2 fetch after near jump", fetch_addr, model_addr(32'hFFFF0000, 32'h100, 1'b0));
  endtask

  task automatic t_real_load;
    do_sel(16'h1234, 32'hDEAD_BEEF, 32'h0000_0010);
    chk("R3 selector", {16'h0, seg_sel}, 32'h00001234);
    chk("R3 base", seg_base, 32'h00012340);
    chk("R3 limit", seg_limit, 32'h0000FFFF);
    chk("R2 fetch", fetch_addr, 32'h00012440);
  endtask

  task automatic t_mode_toggle;
    @(negedge clk); prot_mode = 1'b1;
    @(negedge clk);
    chk("R5 base after entering prot", seg_base, 32'h00012340);
    chk("R5 selector after entering prot", {16'h0, seg_sel}, 32'h00001234);
    @(negedge clk); prot_mode = 1'b0;
    @(negedge clk);
    chk("R5 base after leaving prot", seg_base, 32'h00012340);
    chk("R5 limit after toggle", seg_limit, 32'h0000FFFF);
  endtask

  task automatic t_offset_width;
    do_ip(32'h0001_0010);
    chk("R7 real-mode truncated fetch", fetch_addr, 32'h00012350);
    chk("R8 no fault in real", {31'h0, limit_fault}, 32'h0);
    @(negedge clk); prot_mode = 1'b1;
    #1;
    chk("R7 full offset in prot", fetch_addr, 32'h00022350);
    chk("R8 fault when over limit", {31'h0, limit_fault}, 32'h1);
    @(negedge clk);
    chk("R8 fault leaves base", seg_base, 32'h00012340);
    chk("R8 fault leaves offset", ip_off, 32'h00010010);
  endtask

  task automatic t_prot_load_then_real;
    do_sel(16'h0008, 32'h0040_0000, 32'h000F_FFFF);
    chk("R4 selector", {16'h0, seg_sel}, 32'h00000008);
    chk("R4 base from descriptor", seg_base, 32'h00400000);
    chk("R4 limit from descriptor", seg_limit, 32'h000FFFFF);
    chk("R2 prot fetch", fetch_addr, 32'h00410010);
    chk("R8 within descriptor limit", {31'h0, limit_fault}, 32'h0);
    @(negedge clk); prot_mode = 1'b0;
    @(negedge clk);
    chk("R5 prot base kept in real", seg_base, 32'h00400000);
    chk("R5 limit kept in real", seg_limit, 32'h000FFFFF);
    chk("R7 real fetch with prot base", fetch_addr, 32'h00400010);
  endtask

  task automatic t_small_limit;
    @(negedge clk); prot_mode = 1'b1;
    do_sel(16'h0010, 32'h0010_0000, 32'h0000_0FFF);
    do_ip(32'h0000_0FFF);
    chk("R8 offset equal to limit", {31'h0, limit_fault}, 32'h0);
    do_ip(32'h0000_1000);
    chk("R8 offset one past limit", {31'h0, limit_fault}, 32'h1);
    chk("R2 fetch reported anyway", fetch_addr, 32'h00101000);
  endtask

  task automatic t_wrap;
    do_sel(16'h0018, 32'hFFFF_F000, 32'hFFFF_FFFF);
    do_ip(32'h0000_2000);
    chk("R9 wrapped fetch", fetch_addr, 32'h00001000);
    chk("R8 no fault at max limit", {31'h0, limit_fault}, 32'h0);
  endtask

  task automatic t_joint;
    @(negedge clk); prot_mode = 1'b0;
    @(negedge clk);
    sel_load = 1'b1; sel_value = 16'hF000; ip_load = 1'b1; ip_value = 32'h0000_FFF0;
    @(negedge clk);
    sel_load = 1'b0; ip_load = 1'b0;
    chk("R10 selector", {16'h0, seg_sel}, 32'h0000F000);
    chk("R10 offset", ip_off, 32'h0000FFF0);
    chk("R3 base after far jump", seg_base, 32'h000F0000);
    chk("R10 fetch", fetch_addr, 32'h000FFFF0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_near_jump();
    t_real_load();
    t_mode_toggle();
    t_offset_width();
    t_prot_load_then_real();
    t_small_limit();
    t_wrap();
    t_joint();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule